// File: doc/BRIEF.md
# Hardware Thread Wait-on-Value Monitor

This block parks a hardware thread until a memory word takes an expected value, so the thread never spins on a load. When a thread issues a wait with an address and an expected value, the block records a reservation on that address, drops the thread's dispatch enable and raises its low-power indication. It then watches the stream of snooped writes. When a write lands on the reserved word and carries the expected value, dispatch comes back on the next cycle. No context switch is involved: the thread's state stays where it is and only dispatch is gated.

Each thread slot is independent, and one snooped write can release several threads that watch the same word. The load path supplies the current value of the word along with the request. If that value already equals the expected one, the thread keeps running. An external interrupt aimed at a parked thread also ends the wait, and a cause flag records that the thread was released by the interrupt and not by a value match.

Top module: `wov_monitor`

## Requirements
- R1: A wait request for a running thread whose current value differs from the expected value clears that thread's `dispatch_en_o` bit from the cycle after the request.
- R2: A thread's `low_power_o` bit is 1 exactly in the cycles in which its dispatch is held off by a wait.
- R3: A wait request whose current value equals the expected value leaves the thread dispatching.
- R4: A wait request for a thread that is already parked is ignored: the original reservation and expected value stay in force.
- R5: A snooped write whose byte address equals the reserved address and whose data equals the expected value restores dispatch in the next cycle and leaves `irq_cause_o` at 0.
- R6: A parked thread stays parked, with its reservation unchanged, when a snooped write carries a different value, hits another word of the same 64-byte line, or hits another line.
- R7: An `irq_i` bit asserted for a parked thread restores dispatch in the next cycle and sets its `irq_cause_o` bit; the flag holds until the thread's next accepted wait request clears it. An interrupt for a running thread has no effect.
- R8: A value match wins over an interrupt in the same cycle (cause stays 0), and a matching snooped write in the same cycle as a wait request keeps the thread from parking.
- R9: Threads are independent: a single snooped write releases every parked thread whose reservation and expected value it matches, and no other.
- R10: After reset all threads dispatch, no thread is in low power and all cause flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wait_vld_i | input | 1 | Wait request strobe |
| wait_tid_i | input | TID_W | Thread issuing the wait |
| wait_addr_i | input | ADDR_W | Byte address of the watched word |
| wait_exp_i | input | DATA_W | Value the thread waits for |
| wait_cur_i | input | DATA_W | Current value of the word at request time |
| snp_vld_i | input | 1 | Snooped write strobe |
| snp_addr_i | input | ADDR_W | Byte address of the snooped write |
| snp_data_i | input | DATA_W | Word written by the snooped write |
| irq_i | input | NUM_THREADS | Per-thread external interrupt |
| dispatch_en_o | output | NUM_THREADS | Per-thread dispatch enable |
| low_power_o | output | NUM_THREADS | Per-thread low-power indication |
| irq_cause_o | output | NUM_THREADS | Per-thread flag: last wait ended by interrupt |

## Verification
Two pairs of events can coincide: a matching snooped write with an interrupt for the same parked thread, and a matching snooped write with a wait request from a running thread. Both are driven deliberately in directed steps and then arise again in a long random phase that draws addresses and values from small pools so collisions are frequent. A behavioural model in the bench applies the priority rules of R8 and is compared with all three outputs of every thread on every clock.

// File: rtl/wov_pkg.sv
package wov_pkg;
  typedef enum logic {
    TH_RUN  = 1'b0,
    TH_PARK = 1'b1
  } th_state_e;
endpackage

// File: rtl/wov_snoop_cmp.sv
module wov_snoop_cmp #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic              vld_i,
  input  logic [ADDR_W-1:0] ref_addr_i,
  input  logic [DATA_W-1:0] ref_val_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              line_hit_o,
  output logic              wake_o
);
  localparam int LINE_OFF = $clog2(LINE_BYTES);

  logic off_eq;

  // reservation granule is the line; wake needs the exact word
  assign line_hit_o = vld_i && (ref_addr_i[ADDR_W-1:LINE_OFF] == wr_addr_i[ADDR_W-1:LINE_OFF]);
  assign off_eq     = (ref_addr_i[LINE_OFF-1:0] == wr_addr_i[LINE_OFF-1:0]);
  assign wake_o     = line_hit_o && off_eq && (ref_val_i == wr_data_i);
endmodule

// File: rtl/wov_thread_ctl.sv
module wov_thread_ctl
  import wov_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_exp_i,
  input  logic [DATA_W-1:0] req_cur_i,
  input  logic              snp_vld_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [DATA_W-1:0] snp_data_i,
  input  logic              irq_i,
  output logic              dispatch_en_o,
  output logic              low_power_o,
  output logic              irq_cause_o
);
  th_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q;
  logic              cause_q, cause_d;
  logic              resv_wake, req_wake;
  logic              resv_line, req_line;
  logic              accept, park;

  // snoop against the held reservation
  wov_snoop_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)) u_resv_cmp (
    .vld_i     (snp_vld_i),
    .ref_addr_i(addr_q),
    .ref_val_i (exp_q),
    .wr_addr_i (snp_addr_i),
    .wr_data_i (snp_data_i),
    .line_hit_o(resv_line),
    .wake_o    (resv_wake)
  );

  // snoop against a request arriving this cycle
  wov_snoop_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)) u_req_cmp (
    .vld_i     (snp_vld_i),
    .ref_addr_i(req_addr_i),
    .ref_val_i (req_exp_i),
    .wr_addr_i (snp_addr_i),
    .wr_data_i (snp_data_i),
    .line_hit_o(req_line),
    .wake_o    (req_wake)
  );

  assign accept = req_i && (state_q == TH_RUN);
  assign park   = accept && (req_cur_i != req_exp_i) && !req_wake;

  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    if (state_q == TH_PARK) begin
      if (resv_wake) begin
        state_d = TH_RUN;
        cause_d = 1'b0;
      end else if (irq_i) begin
        state_d = TH_RUN;
        cause_d = 1'b1;
      end
    end else if (accept) begin
      cause_d = 1'b0;
      if (park) state_d = TH_PARK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TH_RUN;
      cause_q <= 1'b0;
      addr_q  <= '0;
      exp_q   <= '0;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
      if (park) begin
        addr_q <= req_addr_i;
        exp_q  <= req_exp_i;
      end
    end
  end

  assign dispatch_en_o = (state_q == TH_RUN);
  assign low_power_o   = (state_q == TH_PARK);
  assign irq_cause_o   = cause_q;

  a_r1_park_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dispatch_en_o && req_i && (req_cur_i != req_exp_i) && !req_wake) |=> (!dispatch_en_o && low_power_o));

  a_r3_no_park_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dispatch_en_o && req_i && (req_cur_i == req_exp_i)) |=> dispatch_en_o);

  a_r4_rewait_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_power_o && req_i) |=> ($stable(addr_q) && $stable(exp_q)));

  a_r5_wake_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_power_o && resv_wake) |=> (dispatch_en_o && !irq_cause_o));

  a_r6_hold_on_other: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_power_o && !resv_wake && !irq_i) |=> (low_power_o && $stable(addr_q) && $stable(exp_q)));

  a_r7_irq_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_power_o && irq_i && !resv_wake) |=> (dispatch_en_o && irq_cause_o));

  a_r8_req_snoop_race: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dispatch_en_o && req_i && req_wake && req_line) |=> dispatch_en_o);

  a_r6_line_only_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_power_o && resv_line && (snp_addr_i != addr_q) && !irq_i) |=> low_power_o);
endmodule

// File: rtl/wov_monitor.sv
module wov_monitor #(
  parameter int NUM_THREADS = 4,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_BYTES  = 64,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wait_vld_i,
  input  logic [TID_W-1:0]       wait_tid_i,
  input  logic [ADDR_W-1:0]      wait_addr_i,
  input  logic [DATA_W-1:0]      wait_exp_i,
  input  logic [DATA_W-1:0]      wait_cur_i,
  input  logic                   snp_vld_i,
  input  logic [ADDR_W-1:0]      snp_addr_i,
  input  logic [DATA_W-1:0]      snp_data_i,
  input  logic [NUM_THREADS-1:0] irq_i,
  output logic [NUM_THREADS-1:0] dispatch_en_o,
  output logic [NUM_THREADS-1:0] low_power_o,
  output logic [NUM_THREADS-1:0] irq_cause_o
);
  logic [NUM_THREADS-1:0] req_sel;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign req_sel[t] = wait_vld_i && (wait_tid_i == TID_W'(t));

    wov_thread_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)) u_ctl (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_i        (req_sel[t]),
      .req_addr_i   (wait_addr_i),
      .req_exp_i    (wait_exp_i),
      .req_cur_i    (wait_cur_i),
      .snp_vld_i    (snp_vld_i),
      .snp_addr_i   (snp_addr_i),
      .snp_data_i   (snp_data_i),
      .irq_i        (irq_i[t]),
      .dispatch_en_o(dispatch_en_o[t]),
      .low_power_o  (low_power_o[t]),
      .irq_cause_o  (irq_cause_o[t])
    );
  end

  a_r2_one_request_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_sel));

  a_r2_lp_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_power_o & dispatch_en_o) == '0);
endmodule

// File: tb/wov_monitor_tb.sv
`timescale 1ns/1ps
module wov_monitor_tb;
  localparam int NT = 4;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wait_vld = 1'b0;
  logic [1:0]    wait_tid = '0;
  logic [AW-1:0] wait_addr = '0;
  logic [DW-1:0] wait_exp = '0;
  logic [DW-1:0] wait_cur = '0;
  logic          snp_vld = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic [DW-1:0] snp_data = '0;
  logic [NT-1:0] irq = '0;
  logic [NT-1:0] dsp, lp, cause;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference model state
  bit            m_park [NT];
  bit            m_cause[NT];
  logic [AW-1:0] m_addr [NT];
  logic [DW-1:0] m_exp  [NT];

  always #5 clk = ~clk;

  wov_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wait_vld_i(wait_vld), .wait_tid_i(wait_tid), .wait_addr_i(wait_addr),
    .wait_exp_i(wait_exp), .wait_cur_i(wait_cur),
    .snp_vld_i(snp_vld), .snp_addr_i(snp_addr), .snp_data_i(snp_data),
    .irq_i(irq), .dispatch_en_o(dsp), .low_power_o(lp), .irq_cause_o(cause)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) begin
        m_park[t] = 0; m_cause[t] = 0; m_addr[t] = '0; m_exp[t] = '0;
      end
    end else begin
      for (int t = 0; t < NT; t++) begin
        if (m_park[t]) begin
          if (snp_vld && snp_addr == m_addr[t] && snp_data == m_exp[t]) begin
            m_park[t] = 0; m_cause[t] = 0;
          end else if (irq[t]) begin
            m_park[t] = 0; m_cause[t] = 1;
          end
        end else if (wait_vld && wait_tid == t) begin
          m_cause[t] = 0;
          if (wait_cur != wait_exp &&
              !(snp_vld && snp_addr == wait_addr && snp_data == wait_exp)) begin
            m_park[t] = 1; m_addr[t] = wait_addr; m_exp[t] = wait_exp;
          end
        end
      end
    end
  end

  task automatic compare(string note);
    for (int t = 0; t < NT; t++) begin
      vectors++;
      if (dsp[t] !== !m_park[t]) begin
        miscompares++;
        $display("FAIL R5 %s thread %0d dispatch act=%b exp=%b", note, t, dsp[t], !m_park[t]);
      end
      if (lp[t] !== m_park[t]) begin
        miscompares++;
        $display("FAIL R2 %s thread %0d low_power act=%b exp=%b", note, t, lp[t], m_park[t]);
      end
      if (cause[t] !== m_cause[t]) begin
        miscompares++;
        $display("FAIL R7 %s thread %0d cause act=%b exp=%b", note, t, cause[t], m_cause[t]);
      end
    end
  endtask

  task automatic idle_in();
    wait_vld = 0; snp_vld = 0; irq = '0;
  endtask

  // one cycle: check outputs, then drive the next inputs
  task automatic step(string note);
    @(negedge clk);
    compare(note);
    idle_in();
  endtask

  task automatic req(int t, logic [AW-1:0] a, logic [DW-1:0] e, logic [DW-1:0] c);
    wait_vld = 1; wait_tid = 2'(t); wait_addr = a; wait_exp = e; wait_cur = c;
  endtask

  task automatic snoop(logic [AW-1:0] a, logic [DW-1:0] d);
    snp_vld = 1; snp_addr = a; snp_data = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R10 in reset");
    rst_n = 1;
    step("R10 after reset");
    // R1 R2: park thread 0
    req(0, 32'h1000, 32'd5, 32'd3);
    step("R1 park");
    step("R1 parked");
    // R6: other value, other word in line, other line
    snoop(32'h1000, 32'd4); step("R6 wrong value");
    snoop(32'h1004, 32'd5); step("R6 same line other word");
    snoop(32'h2000, 32'd5); step("R6 other line");
    step("R6 still parked");
    // R5: matching write
    snoop(32'h1000, 32'd5); step("R5 match");
    step("R5 woke");
    // R3: already holds value
    req(1, 32'h1040, 32'd9, 32'd9); step("R3 no park");
    step("R3 running");
    // R4: re-wait ignored
    req(1, 32'h1040, 32'd9, 32'd1); step("R4 park");
    req(1, 32'h3000, 32'd7, 32'd1); step("R4 rewait");
    snoop(32'h3000, 32'd7); step("R4 new target no effect");
    snoop(32'h1040, 32'd9); step("R4 old target wakes");
    step("R4 woke");
    // R7: interrupt wake, then irq to running thread
    req(2, 32'h5000, 32'd1, 32'd0); step("R7 park");
    irq[2] = 1; step("R7 irq");
    irq[2] = 1; step("R7 irq while running");
    req(2, 32'h5000, 32'd1, 32'd0); step("R7 cause cleared by wait");
    // R8: irq with match same cycle
    irq[2] = 1; snoop(32'h5000, 32'd1); step("R8 irq and match");
    step("R8 cause zero");
    // R8: request coincides with matching write
    req(3, 32'h6000, 32'd2, 32'd0); snoop(32'h6000, 32'd2); step("R8 req and match");
    step("R8 no park");
    // R9: two threads on one word, one on another
    req(0, 32'h7000, 32'd8, 32'd0); step("R9 park t0");
    req(1, 32'h7000, 32'd8, 32'd0); step("R9 park t1");
    req(3, 32'h7000, 32'd6, 32'd0); step("R9 park t3");
    snoop(32'h7000, 32'd8); step("R9 shared release");
    step("R9 t3 stays");
    irq = '1; step("R9 clear");
    step("R9 settled");
    // random phase, small pools for collisions
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 2) == 0)
        req($urandom_range(0, NT - 1), 32'h8000 + 4 * $urandom_range(0, 3),
            $urandom_range(0, 3), $urandom_range(0, 3));
      if ($urandom_range(0, 1) == 0)
        snoop(32'h8000 + 4 * $urandom_range(0, 3), $urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) irq = 4'($urandom_range(0, 15));
      step("R8 random");
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule